// File: doc/BRIEF.md
# Bit-Oriented Frame Receiver with Station Address Filter

This block sits after clock recovery and line decoding. It takes one serial bit per `bit_en` strobe and searches the stream for the flag pattern `01111110`. Between flags it deletes the zeros the sender inserted for transparency and rebuilds bytes, least significant bit first. It keeps a running CRC-16-CCITT over each frame and can throw away any frame whose leading byte is not the programmed station address.

Payload bytes go into a small data FIFO. The two CRC bytes that close every frame are checked and then dropped. Each completed or aborted frame leaves one 19-bit status word in a separate status FIFO. The word gives the frame's byte count and its error flags. The host drains both FIFOs through pop strobes and matches each status word against the bytes it has already read.

Top module: `hdlc_frame_rx`

## Requirements
- R1: After reset, both `rx_avail` and `st_avail` are low.
- R2: The bytes of a frame, excluding its final two CRC bytes, appear on `rx_data` in the order they were received. Each byte is assembled with its first received bit as bit 0. A pop while `rx_avail` is low changes nothing.
- R3: Inside a frame, a 0 that follows five consecutive 1s is removed before byte assembly.
- R4: Status word layout is [13:0] byte count (bytes excluding the CRC), [14] residue, [15] end-of-frame (closing flag seen), [16] overrun, [17] abort, [18] CRC error. A well-formed frame yields count = payload length and flags 0,0,0,1,0 in the order [18]..[14].
- R5: A frame whose CRC-16-CCITT register fails the check sets bit [18]. The register is reflected, uses polynomial 0x8408 and starts at 0xFFFF. A frame passes when the register, run over the payload plus the received CRC, ends at 0xF0B8.
- R6: When `addr_en` is high, the block keeps only frames whose first byte equals `station_addr` or 0xFF. Any other frame produces no data and no status word.
- R7: Seven consecutive 1s inside a frame, after at least one byte has been assembled, push a status word with bit [17] set and bit [15] clear. The count field holds the bytes already delivered. The receiver then waits for a new flag.
- R8: A single flag can close one frame and open the next.
- R9: A frame with fewer than two assembled bytes between flags produces no data and no status.
- R10: If 1 to 7 bits are left over after the last whole byte when the closing flag arrives, bit [14] is set.
- R11: A byte that arrives while the data FIFO (depth 8) is full is lost, and its frame's status word has bit [16] set. The count field still includes the lost byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Marks the cycle in which `rx_bit` is valid |
| rx_bit | input | 1 | Recovered serial data bit |
| addr_en | input | 1 | Turns on station address filtering |
| station_addr | input | 8 | Station address that frames are compared against |
| rx_pop | input | 1 | Removes the head byte of the data FIFO |
| rx_data | output | 8 | Head byte of the data FIFO |
| rx_avail | output | 1 | Data FIFO is not empty |
| st_pop | input | 1 | Removes the head word of the status FIFO |
| st_word | output | 19 | Head word of the status FIFO |
| st_avail | output | 1 | Status FIFO is not empty |

## Verification
The checker watches the data FIFO's occupancy on every cycle. Occupancy may move by at most one per cycle, must not drop below empty when the host pops with nothing stored, and must stay full while no pop arrives. The checker also requires that status words are written only on bit strobes and that no word is marked both aborted and ended by a flag. Several behaviours can only be shown by bench scenarios whose expected bytes and status words are computed independently of the RTL. These are zero deletion, the CRC check, address and broadcast filtering, flag sharing, the short-frame drop, residue, abort counting and overrun accounting.

// File: rtl/hdlc_frame_rx.sv
module hdlc_frame_rx #(
  parameter int DATA_DEPTH = 8,
  parameter int STAT_DEPTH = 10,
  parameter int CNT_W      = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             rx_bit,
  input  logic             addr_en,
  input  logic [7:0]       station_addr,
  input  logic             rx_pop,
  output logic [7:0]       rx_data,
  output logic             rx_avail,
  input  logic             st_pop,
  output logic [CNT_W+4:0] st_word,
  output logic             st_avail
);
  localparam int SW  = CNT_W + 5;
  localparam int DAW = (DATA_DEPTH > 1) ? $clog2(DATA_DEPTH) : 1;
  localparam int DCW = $clog2(DATA_DEPTH + 1);
  localparam int SAW = (STAT_DEPTH > 1) ? $clog2(STAT_DEPTH) : 1;
  localparam int SCW = $clog2(STAT_DEPTH + 1);
  localparam logic [DCW-1:0] DFULL = DCW'(DATA_DEPTH);
  localparam logic [SCW-1:0] SFULL = SCW'(STAT_DEPTH);
  localparam logic [DAW-1:0] DLAST = DAW'(DATA_DEPTH - 1);
  localparam logic [SAW-1:0] SLAST = SAW'(STAT_DEPTH - 1);
  localparam logic [15:0] CRC_INIT = 16'hFFFF;
  localparam logic [15:0] CRC_GOOD = 16'hF0B8;
  localparam logic [15:0] CRC_POLY = 16'h8408;

  logic [2:0]       ones, dfill, bpos;
  logic             sync, ovr;
  logic [6:0]       dly;
  logic [7:0]       asm_q, h_old, h_new;
  logic [1:0]       nb;
  logic [15:0]      crc;
  logic [CNT_W-1:0] fcnt;

  logic [7:0]     dmem [DATA_DEPTH];
  logic [DAW-1:0] dwp, drp;
  logic [DCW-1:0] dcount;
  logic [SW-1:0]  smem [STAT_DEPTH];
  logic [SAW-1:0] swp, srp;
  logic [SCW-1:0] scount;

  wire is_flag  = bit_en & ~rx_bit & (ones == 3'd6);
  wire is_abort = bit_en &  rx_bit & (ones == 3'd6);
  wire is_stuff = bit_en & ~rx_bit & (ones == 3'd5);
  wire take     = bit_en & sync & ~is_flag & ~is_abort & ~is_stuff;
  wire emit     = take & (dfill == 3'd7);
  wire ob       = dly[0];
  wire byte_done = emit & (bpos == 3'd7);
  wire [7:0] nbyte = {ob, asm_q[7:1]};
  wire addr_ok  = ~addr_en | (nbyte == station_addr) | (nbyte == 8'hFF);
  wire addr_drop = byte_done & (nb == 2'd0) & ~addr_ok;
  wire d_wr     = byte_done & ~addr_drop & (nb == 2'd2);
  wire d_full   = (dcount == DFULL);
  wire d_push   = d_wr & ~d_full;
  wire d_pop    = rx_pop & (dcount != '0);
  wire fb       = crc[0] ^ ob;
  wire [15:0] crc_nx = {1'b0, crc[15:1]} ^ (fb ? CRC_POLY : 16'h0000);

  wire close     = is_flag & sync & (nb == 2'd2);
  wire abort_rep = is_abort & sync & (nb != 2'd0);
  wire st_wr     = close | abort_rep;
  wire [SW-1:0] st_in = {close & (crc != CRC_GOOD), abort_rep, ovr, close,
                         close & (bpos != 3'd0), fcnt};
  wire s_push = st_wr & (scount != SFULL);
  wire s_pop  = st_pop & (scount != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones <= '0; sync <= 1'b0; dly <= '0; dfill <= '0; asm_q <= '0;
      bpos <= '0; nb <= '0; h_old <= '0; h_new <= '0; crc <= CRC_INIT;
      fcnt <= '0; ovr <= 1'b0;
    end else if (bit_en) begin
      ones <= rx_bit ? ((ones == 3'd7) ? 3'd7 : ones + 3'd1) : 3'd0;
      if (is_flag) begin
        sync <= 1'b1; dfill <= '0; bpos <= '0; nb <= '0;
        crc <= CRC_INIT; fcnt <= '0; ovr <= 1'b0;
      end else if (is_abort) begin
        sync <= 1'b0;
      end else if (take) begin
        dly <= {rx_bit, dly[6:1]};
        if (dfill != 3'd7) dfill <= dfill + 3'd1;
        if (emit) begin
          asm_q <= nbyte;
          bpos  <= bpos + 3'd1;
          crc   <= crc_nx;
        end
        if (byte_done) begin
          if (addr_drop) sync <= 1'b0;
          else begin
            if (nb != 2'd2) nb <= nb + 2'd1;
            h_old <= h_new;
            h_new <= nbyte;
            if (nb == 2'd2) begin
              fcnt <= fcnt + 1'b1;
              if (d_full) ovr <= 1'b1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (d_push) dmem[dwp] <= h_old;
    if (s_push) smem[swp] <= st_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dwp <= '0; drp <= '0; dcount <= '0;
      swp <= '0; srp <= '0; scount <= '0;
    end else begin
      if (d_push) dwp <= (dwp == DLAST) ? '0 : dwp + 1'b1;
      if (d_pop)  drp <= (drp == DLAST) ? '0 : drp + 1'b1;
      dcount <= dcount + DCW'(d_push) - DCW'(d_pop);
      if (s_push) swp <= (swp == SLAST) ? '0 : swp + 1'b1;
      if (s_pop)  srp <= (srp == SLAST) ? '0 : srp + 1'b1;
      scount <= scount + SCW'(s_push) - SCW'(s_pop);
    end
  end

  assign rx_data  = dmem[drp];
  assign rx_avail = (dcount != '0);
  assign st_word  = smem[srp];
  assign st_avail = (scount != '0);
endmodule

// File: rtl/hdlc_frame_rx_chk.sv
module hdlc_frame_rx_chk #(
  parameter int DATA_DEPTH = 8,
  parameter int CNT_W      = 14
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              bit_en,
  input logic                              rx_pop,
  input logic                              rx_avail,
  input logic                              st_avail,
  input logic                              st_wr,
  input logic [CNT_W+4:0]                  st_in,
  input logic                              d_wr,
  input logic [$clog2(DATA_DEPTH+1)-1:0]   dcount
);
  localparam int DCW = $clog2(DATA_DEPTH + 1);
  localparam logic [DCW-1:0] FULL = DCW'(DATA_DEPTH);

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!rx_avail && !st_avail));

  p_pop_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && dcount == '0 && !d_wr) |=> (dcount == '0));

  p_stat_on_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr |-> bit_en);

  p_abort_not_eof_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr |-> !(st_in[CNT_W+3] && st_in[CNT_W+1]));

  p_full_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dcount == FULL && !rx_pop) |=> (dcount == FULL));

  p_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((dcount <= $past(dcount) + 1'b1) && (dcount + 1'b1 >= $past(dcount))));
endmodule

bind hdlc_frame_rx hdlc_frame_rx_chk #(.DATA_DEPTH(DATA_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_pop(rx_pop),
  .rx_avail(rx_avail), .st_avail(st_avail), .st_wr(st_wr), .st_in(st_in),
  .d_wr(d_wr), .dcount(dcount)
);

// File: tb/tb_hdlc_frame_rx.sv
`timescale 1ns/1ps
module tb_hdlc_frame_rx;
  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, rx_bit = 1'b1;
  logic addr_en = 1'b0, rx_pop = 1'b0, st_pop = 1'b0;
  logic [7:0] station_addr = 8'h00;
  logic [7:0] rx_data;
  logic [18:0] st_word;
  logic rx_avail, st_avail;

  always #2.5 clk = ~clk;

  hdlc_frame_rx dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .addr_en(addr_en), .station_addr(station_addr),
    .rx_pop(rx_pop), .rx_data(rx_data), .rx_avail(rx_avail),
    .st_pop(st_pop), .st_word(st_word), .st_avail(st_avail)
  );

  int checks = 0, fails = 0, tx_ones = 0;
  bit mon_en = 1'b1, done = 1'b0;
  logic [7:0]  exp_d[$];
  string       tag_d[$];
  logic [18:0] exp_s[$];
  string       tag_s[$];
  logic [7:0]  fr[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_b(logic [15:0] c, logic [7:0] v);
    for (int i = 0; i < 8; i++)
      c = (c[0] ^ v[i]) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    return c;
  endfunction

  function automatic logic [18:0] sw(bit ce, bit ab, bit ov, bit eo, bit rs, int n);
    return {ce, ab, ov, eo, rs, 14'(n)};
  endfunction

  always @(negedge clk) begin
    rx_pop = 1'b0;
    st_pop = 1'b0;
    if (rst_n && mon_en && rx_avail) begin
      if (exp_d.size() == 0) chk("R2 unexpected byte", {24'h0, rx_data}, 32'hFFFF_FFFF);
      else chk(tag_d.pop_front(), {24'h0, rx_data}, {24'h0, exp_d.pop_front()});
      rx_pop = 1'b1;
    end
    if (rst_n && st_avail) begin
      if (exp_s.size() == 0) chk("R6/R9 unexpected status", {13'h0, st_word}, 32'hFFFF_FFFF);
      else chk(tag_s.pop_front(), {13'h0, st_word}, {13'h0, exp_s.pop_front()});
      st_pop = 1'b1;
    end
  end

  task automatic send_raw(bit b);
    @(negedge clk); bit_en = 1'b1; rx_bit = b;
    @(negedge clk); bit_en = 1'b0;
  endtask

  task automatic send_flag();
    send_raw(0); for (int i = 0; i < 6; i++) send_raw(1); send_raw(0);
  endtask

  task automatic send_dbit(bit b);
    send_raw(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin send_raw(0); tx_ones = 0; end
    end else tx_ones = 0;
  endtask

  task automatic send_byte(logic [7:0] v);
    for (int i = 0; i < 8; i++) send_dbit(v[i]);
  endtask

  task automatic send_frame(bit bad);
    logic [15:0] c = 16'hFFFF;
    tx_ones = 0;
    foreach (fr[i]) begin send_byte(fr[i]); c = crc_b(c, fr[i]); end
    c = ~c;
    if (bad) c[0] = ~c[0];
    send_byte(c[7:0]);
    send_byte(c[15:8]);
  endtask

  task automatic expect_frame(bit ce, string tag);
    foreach (fr[i]) begin exp_d.push_back(fr[i]); tag_d.push_back(tag); end
    exp_s.push_back(sw(ce, 0, 0, 1, 0, fr.size()));
    tag_s.push_back({tag, " status"});
  endtask

  task automatic drain(string tag);
    repeat (60) @(negedge clk);
    chk({tag, " data queue empty"}, exp_d.size(), 0);
    chk({tag, " status queue empty"}, exp_s.size(), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #750000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 rx_avail after reset", rx_avail, 0);
    chk("R1 st_avail after reset", st_avail, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 rx_avail idle", rx_avail, 0);
    chk("R1 st_avail idle", st_avail, 0);

    // R2 R4 plain frame
    fr = {8'h12, 8'h34, 8'h56};
    expect_frame(0, "R2 R4 plain");
    send_flag(); send_frame(0); send_flag();
    drain("R2");

    // R3 zero deletion
    fr = {8'hFF, 8'h7E, 8'h3F, 8'hF8, 8'h1F};
    expect_frame(0, "R3 stuffing");
    send_flag(); send_frame(0); send_flag();
    drain("R3");

    // R5 CRC error
    fr = {8'hA5, 8'h5A};
    expect_frame(1, "R5 bad crc");
    send_flag(); send_frame(1); send_flag();
    drain("R5");

    // R6 address filter with broadcast; R8 shared flags
    addr_en = 1'b1; station_addr = 8'h5A;
    send_flag();
    fr = {8'h5A, 8'h01}; expect_frame(0, "R6 match"); send_frame(0); send_flag();
    fr = {8'hFF, 8'h02}; expect_frame(0, "R6 broadcast"); send_frame(0); send_flag();
    fr = {8'h33, 8'h03}; send_frame(0); send_flag();
    fr = {8'h5A, 8'h04}; expect_frame(0, "R6 R8 after drop"); send_frame(0); send_flag();
    drain("R6 R8");
    addr_en = 1'b0;

    // R8 shared flag between frames
    send_flag();
    fr = {8'hC3}; expect_frame(0, "R8 first"); send_frame(0); send_flag();
    fr = {8'h3C, 8'h99}; expect_frame(0, "R8 second"); send_frame(0); send_flag();
    drain("R8");

    // R7 abort
    send_flag();
    tx_ones = 0;
    exp_d.push_back(8'h11); tag_d.push_back("R7 abort data");
    exp_s.push_back(sw(0, 1, 0, 0, 0, 1)); tag_s.push_back("R7 abort status");
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44);
    for (int i = 0; i < 10; i++) send_raw(1);
    drain("R7");

    // R9 short frame, then a normal one
    send_flag(); tx_ones = 0; send_byte(8'h42); send_flag();
    fr = {8'h77}; expect_frame(0, "R9 after short"); send_frame(0); send_flag();
    drain("R9");

    // R10 residue
    fr = {8'h21, 8'h43, 8'h65};
    foreach (fr[i]) begin exp_d.push_back(fr[i]); tag_d.push_back("R10 residue data"); end
    exp_s.push_back(sw(1, 0, 0, 1, 1, 3)); tag_s.push_back("R10 residue status");
    send_flag(); send_frame(0);
    send_dbit(0); send_dbit(0); send_dbit(0);
    send_flag();
    drain("R10");

    // R11 overrun
    mon_en = 1'b0;
    fr = {};
    for (int i = 1; i <= 12; i++) fr.push_back(8'(i));
    for (int i = 0; i < 8; i++) begin exp_d.push_back(fr[i]); tag_d.push_back("R11 kept data"); end
    exp_s.push_back(sw(0, 0, 1, 1, 0, 12)); tag_s.push_back("R11 overrun status");
    send_flag(); send_frame(0); send_flag();
    repeat (20) @(negedge clk);
    chk("R11 fifo full", rx_avail, 1);
    mon_en = 1'b1;
    drain("R11");

    finish_run();
  end
endmodule